// File: doc/BRIEF.md
# Three-Bus Microcoded Register Datapath

This block is the register-and-ALU core of a small 16-bit processor that is steered entirely by a flat control word. Each clock carries out one micro-operation. The word picks at most one register to drive each of the two ALU operand buses (X and Y) and picks the ALU function. It also says which registers capture the result bus, whether the zero flag updates, whether the program counter load depends on that flag, how the stack pointer steps, and whether memory is read or written. Instruction decode and sequencing sit outside, in whatever produces the control word.

There are eleven 16-bit registers: two general registers, three instruction-word registers, the program counter, the memory address register, a read buffer, a write buffer, a stack pointer and a return-address register. Memory is external and synchronous. Its address always comes from the memory address register and its write data from the write buffer. The read data is returned combinationally and is captured by the read buffer at the next edge.

Top module: `mdp_datapath`

## Requirements
- R1: After a synchronous active-low reset, every register holds 0x0000 and the zero flag is 0.
- R2: Operand bus X (and Y likewise) carries the register whose bit is set in its enable vector, and 0x0000 when no bit is set. Register indices are G0=0, G1=1, W0=2, W1=3, W2=4, PC=5, MAR=6, RDB=7, WRB=8, SP=9, RA=10. Setting more than one bit on a bus in one cycle is illegal.
- R3: A register captures the result bus only at an edge where its load-enable bit is set; otherwise it holds. Several registers may capture the same result in one cycle.
- R4: The 4-bit function code selects the result: 0 pass X, 1 pass Y, 2 X+Y, 3 X−Y, 4 AND, 5 OR, 6 XOR, 7 NOT X, 8 X shifted left by 1, 9 X logically shifted right by 1, 10 X arithmetically shifted right by 1, 11 0x0001 if X<Y unsigned else 0x0000, and 12 to 15 give 0x0000. Sums and differences wrap modulo 2^16.
- R5: The zero flag changes only at an edge where the flag-update input is 1, and then becomes 1 exactly when the 16-bit result is 0x0000.
- R6: With the conditional-PC input set, the PC loads only if the zero flag (as held before the edge) is 1; otherwise it holds.
- R7: The stack pointer loads the result when its load bit is set, which takes priority over stepping. Otherwise increment alone adds 1, decrement alone subtracts 1, and both together leave it unchanged. It wraps modulo 2^16.
- R8: The memory address output equals MAR, the write-data output equals WRB, and the read/write strobes follow the control inputs. When the read strobe is set, RDB captures the memory read data at the next edge, ahead of its own load bit.
- R9: The result output shows the ALU result combinationally within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_en | input | 11 | Source enables for operand bus X, one bit per register |
| y_en | input | 11 | Source enables for operand bus Y, one bit per register |
| ld_en | input | 11 | Per-register capture enables from the result bus |
| alu_fn | input | 4 | ALU function code |
| flag_upd | input | 1 | Update the zero flag from this cycle's result |
| pc_if_zero | input | 1 | Make the PC load conditional on the zero flag |
| sp_inc | input | 1 | Step the stack pointer up |
| sp_dec | input | 1 | Step the stack pointer down |
| mem_rd | input | 1 | Memory read micro-operation |
| mem_wr | input | 1 | Memory write micro-operation |
| mem_rdata | input | 16 | Data returned by memory for the current address |
| mem_addr | output | 16 | Memory address (MAR) |
| mem_wdata | output | 16 | Memory write data (WRB) |
| mem_re | output | 1 | Read strobe to memory |
| mem_we | output | 1 | Write strobe to memory |
| alu_out | output | 16 | Result bus |
| zero | output | 1 | Zero flag |

## Verification
The bench goes after the conditional PC load with the flag both clear and set. A design that ignored the gate would let the PC jump on a clear flag. It checks that the zero flag survives a non-zero result when updating is off; a design that always updated would lose it. The stack pointer is driven through underflow, overflow, simultaneous up and down, and a load that competes with a step, which shows any wrong priority or wrap. A read with the read buffer's own load bit also set, an empty operand bus, and multi-destination captures show a buffer that takes the bus instead of memory, a floating bus, and a capture that reaches only one destination.

// File: rtl/mdp_pkg.sv
`timescale 1ns/1ps
// mdp_pkg: shared constants for the three-bus datapath.
// Register indices fix bit positions in the per-register control vectors.
package mdp_pkg;
    localparam int DW   = 16;
    localparam int NREG = 11;
    localparam int FW   = 4;

    localparam int R_G0  = 0;
    localparam int R_G1  = 1;
    localparam int R_W0  = 2;
    localparam int R_W1  = 3;
    localparam int R_W2  = 4;
    localparam int R_PC  = 5;
    localparam int R_MAR = 6;
    localparam int R_RDB = 7;
    localparam int R_WRB = 8;
    localparam int R_SP  = 9;
    localparam int R_RA  = 10;

    typedef enum logic [FW-1:0] {
        FN_PASSX = 4'd0,
        FN_PASSY = 4'd1,
        FN_ADD   = 4'd2,
        FN_SUB   = 4'd3,
        FN_AND   = 4'd4,
        FN_OR    = 4'd5,
        FN_XOR   = 4'd6,
        FN_NOTX  = 4'd7,
        FN_SHL   = 4'd8,
        FN_SHR   = 4'd9,
        FN_ASR   = 4'd10,
        FN_LTU   = 4'd11
    } alu_fn_e;
endpackage

// File: rtl/mdp_bus_sel.sv
`timescale 1ns/1ps
// mdp_bus_sel: places one enabled register onto an operand bus.
// Assumes at most one enable is set; if several are, the lowest index wins.
// With no enable set, the bus reads as zero.
module mdp_bus_sel #(
    parameter int DW = 16,
    parameter int N  = 11
) (
    input  logic [N-1:0]  en,
    input  logic [DW-1:0] src [N],
    output logic [DW-1:0] bus
);
    // Priority pick: scan from the top so the lowest enabled index is last written.
    always_comb begin
        bus = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (en[i]) bus = src[i];
        end
    end
endmodule

// File: rtl/mdp_alu.sv
`timescale 1ns/1ps
// mdp_alu: combinational 16-bit function unit fed by the X and Y buses.
// Unused function codes produce zero.
module mdp_alu #(
    parameter int DW = 16,
    parameter int FW = 4
) (
    input  logic [FW-1:0] fn,
    input  logic [DW-1:0] x,
    input  logic [DW-1:0] y,
    output logic [DW-1:0] res
);
    import mdp_pkg::*;

    // Function select.
    always_comb begin
        case (fn)
            FN_PASSX: res = x;
            FN_PASSY: res = y;
            FN_ADD:   res = x + y;
            FN_SUB:   res = x - y;
            FN_AND:   res = x & y;
            FN_OR:    res = x | y;
            FN_XOR:   res = x ^ y;
            FN_NOTX:  res = ~x;
            FN_SHL:   res = {x[DW-2:0], 1'b0};
            FN_SHR:   res = {1'b0, x[DW-1:1]};
            FN_ASR:   res = {x[DW-1], x[DW-1:1]};
            FN_LTU:   res = {{(DW-1){1'b0}}, (x < y)};
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/mdp_sp_ctr.sv
`timescale 1ns/1ps
// mdp_sp_ctr: stack pointer as an up/down counter with parallel load.
// Load beats stepping; up and down together cancel.
module mdp_sp_ctr #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [DW-1:0] ld_val,
    input  logic          inc,
    input  logic          dec,
    output logic [DW-1:0] q
);
    // Counter register with load/step priority.
    always_ff @(posedge clk) begin
        if (!rst_n)           q <= '0;
        else if (ld)          q <= ld_val;
        else if (inc && !dec) q <= q + DW'(1);
        else if (dec && !inc) q <= q - DW'(1);
    end
endmodule

// File: rtl/mdp_datapath.sv
`timescale 1ns/1ps
// mdp_datapath: three-bus register datapath run by a flat control word.
// One micro-operation per clock. Memory is external: address = MAR,
// write data = WRB, read data arrives combinationally and RDB captures it.
// Assumes the sequencer never enables two sources on one bus.
module mdp_datapath #(
    parameter int DW   = mdp_pkg::DW,
    parameter int NREG = mdp_pkg::NREG,
    parameter int FW   = mdp_pkg::FW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] x_en,
    input  logic [NREG-1:0] y_en,
    input  logic [NREG-1:0] ld_en,
    input  logic [FW-1:0]   alu_fn,
    input  logic            flag_upd,
    input  logic            pc_if_zero,
    input  logic            sp_inc,
    input  logic            sp_dec,
    input  logic            mem_rd,
    input  logic            mem_wr,
    input  logic [DW-1:0]   mem_rdata,
    output logic [DW-1:0]   mem_addr,
    output logic [DW-1:0]   mem_wdata,
    output logic            mem_re,
    output logic            mem_we,
    output logic [DW-1:0]   alu_out,
    output logic            zero
);
    import mdp_pkg::*;

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] x_bus;
    logic [DW-1:0] y_bus;
    logic [DW-1:0] c_bus;
    logic          zero_q;

    mdp_bus_sel #(.DW(DW), .N(NREG)) u_xsel (.en(x_en), .src(regs_q), .bus(x_bus));
    mdp_bus_sel #(.DW(DW), .N(NREG)) u_ysel (.en(y_en), .src(regs_q), .bus(y_bus));

    mdp_alu #(.DW(DW), .FW(FW)) u_alu (.fn(alu_fn), .x(x_bus), .y(y_bus), .res(c_bus));

    // Register file: each slot picks its variant by index.
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == R_SP) begin : g_sp
            logic [DW-1:0] q;
            mdp_sp_ctr #(.DW(DW)) u_sp (
                .clk(clk), .rst_n(rst_n), .ld(ld_en[i]), .ld_val(c_bus),
                .inc(sp_inc), .dec(sp_dec), .q(q)
            );
            assign regs_q[i] = q;
        end else if (i == R_RDB) begin : g_rdb
            logic [DW-1:0] q;
            // Read buffer: memory data beats the result bus.
            always_ff @(posedge clk) begin
                if (!rst_n)         q <= '0;
                else if (mem_rd)    q <= mem_rdata;
                else if (ld_en[i])  q <= c_bus;
            end
            assign regs_q[i] = q;
        end else begin : g_plain
            logic [DW-1:0] q;
            logic          wr_ok;
            assign wr_ok = (i == R_PC) ? (ld_en[i] && (!pc_if_zero || zero_q)) : ld_en[i];
            // Plain register: capture result bus when enabled.
            always_ff @(posedge clk) begin
                if (!rst_n)     q <= '0;
                else if (wr_ok) q <= c_bus;
            end
            assign regs_q[i] = q;
        end
    end

    // Zero flag: follows the result only on flag-setting cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)        zero_q <= 1'b0;
        else if (flag_upd) zero_q <= (c_bus == '0);
    end

    assign mem_addr  = regs_q[R_MAR];
    assign mem_wdata = regs_q[R_WRB];
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign alu_out   = c_bus;
    assign zero      = zero_q;
endmodule

// File: rtl/mdp_datapath_chk.sv
`timescale 1ns/1ps
// mdp_datapath_chk: temporal properties of the datapath, bound to the top.
module mdp_datapath_chk #(
    parameter int DW   = 16,
    parameter int NREG = 11
) (
    input logic            clk,
    input logic            rst_n,
    input logic [NREG-1:0] x_en,
    input logic [NREG-1:0] y_en,
    input logic [NREG-1:0] ld_en,
    input logic            flag_upd,
    input logic            pc_if_zero,
    input logic            sp_inc,
    input logic            sp_dec,
    input logic            mem_rd,
    input logic [DW-1:0]   mem_rdata,
    input logic [DW-1:0]   alu_out,
    input logic            zero,
    input logic [DW-1:0]   pc_q,
    input logic [DW-1:0]   sp_q,
    input logic [DW-1:0]   rdb_q,
    input logic [DW-1:0]   g0_q
);
    a_r2_x_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(x_en));
    a_r2_y_single: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(y_en));
    a_r3_g0_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en[mdp_pkg::R_G0] |=> $stable(g0_q));
    a_r5_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_upd |=> $stable(zero));
    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        flag_upd |=> (zero == ($past(alu_out) == '0)));
    a_r6_pc_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_if_zero && !zero) |=> $stable(pc_q));
    a_r7_sp_up: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_inc && !sp_dec && !ld_en[mdp_pkg::R_SP]) |=> (sp_q == $past(sp_q) + DW'(1)));
    a_r7_sp_down: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_dec && !sp_inc && !ld_en[mdp_pkg::R_SP]) |=> (sp_q == $past(sp_q) - DW'(1)));
    a_r8_rd_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> (rdb_q == $past(mem_rdata)));
endmodule

bind mdp_datapath mdp_datapath_chk #(.DW(DW), .NREG(NREG)) u_chk (
    .clk(clk), .rst_n(rst_n), .x_en(x_en), .y_en(y_en), .ld_en(ld_en),
    .flag_upd(flag_upd), .pc_if_zero(pc_if_zero), .sp_inc(sp_inc), .sp_dec(sp_dec),
    .mem_rd(mem_rd), .mem_rdata(mem_rdata), .alu_out(alu_out), .zero(zero),
    .pc_q(regs_q[mdp_pkg::R_PC]), .sp_q(regs_q[mdp_pkg::R_SP]),
    .rdb_q(regs_q[mdp_pkg::R_RDB]), .g0_q(regs_q[mdp_pkg::R_G0])
);

// File: tb/mdp_datapath_tb.sv
`timescale 1ns/1ps
// mdp_datapath_tb: directed corner cases plus seeded random micro-operations,
// compared against a bench-side model built from the requirements.
module mdp_datapath_tb;
    import mdp_pkg::*;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NREG-1:0] x_en = '0, y_en = '0, ld_en = '0;
    logic [3:0]      alu_fn = '0;
    logic            flag_upd = 0, pc_if_zero = 0, sp_inc = 0, sp_dec = 0, mem_rd = 0, mem_wr = 0;
    logic [15:0]     mem_rdata, mem_addr, mem_wdata, alu_out;
    logic            mem_re, mem_we, zero;

    logic [15:0] tmem [256];
    logic [15:0] emem [256];
    logic [15:0] m [NREG];
    logic        mz;
    int          n_chk = 0, n_fail = 0;
    logic [31:0] seed_dummy;

    always #4 clk = ~clk;

    mdp_datapath u_dut (
        .clk(clk), .rst_n(rst_n), .x_en(x_en), .y_en(y_en), .ld_en(ld_en), .alu_fn(alu_fn),
        .flag_upd(flag_upd), .pc_if_zero(pc_if_zero), .sp_inc(sp_inc), .sp_dec(sp_dec),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_re(mem_re), .mem_we(mem_we), .alu_out(alu_out), .zero(zero)
    );

    assign mem_rdata = tmem[mem_addr[7:0]];
    always @(posedge clk) if (mem_we) tmem[mem_addr[7:0]] <= mem_wdata;

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] alu_ref(logic [3:0] f, logic [15:0] x, logic [15:0] y);
        case (f)
            4'd0: return x;
            4'd1: return y;
            4'd2: return x + y;
            4'd3: return x - y;
            4'd4: return x & y;
            4'd5: return x | y;
            4'd6: return x ^ y;
            4'd7: return ~x;
            4'd8: return x << 1;
            4'd9: return x >> 1;
            4'd10: return {x[15], x[15:1]};
            4'd11: return (x < y) ? 16'd1 : 16'd0;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [15:0] pick(logic [NREG-1:0] en);
        for (int i = 0; i < NREG; i++) if (en[i]) return m[i];
        return 16'd0;
    endfunction

    task automatic idle();
        x_en = '0; y_en = '0; ld_en = '0; alu_fn = '0;
        flag_upd = 0; pc_if_zero = 0; sp_inc = 0; sp_dec = 0; mem_rd = 0; mem_wr = 0;
    endtask

    // One micro-operation: inputs set at the falling edge, model committed after the rise.
    task automatic step(string req);
        logic [15:0] c;
        logic [15:0] nm [NREG];
        logic        nz;
        logic [15:0] rd;
        c = alu_ref(alu_fn, pick(x_en), pick(y_en));
        #1;
        chk({req, "/R9 result"}, alu_out, c);
        nm = m; nz = mz;
        rd = emem[m[R_MAR][7:0]];
        for (int i = 0; i < NREG; i++) begin
            if (i == R_SP) begin
                if (ld_en[i]) nm[i] = c;
                else if (sp_inc && !sp_dec) nm[i] = m[i] + 16'd1;
                else if (sp_dec && !sp_inc) nm[i] = m[i] - 16'd1;
            end else if (i == R_RDB) begin
                if (mem_rd) nm[i] = rd;
                else if (ld_en[i]) nm[i] = c;
            end else if (i == R_PC) begin
                if (ld_en[i] && (!pc_if_zero || mz)) nm[i] = c;
            end else if (ld_en[i]) nm[i] = c;
        end
        if (flag_upd) nz = (c == 16'd0);
        if (mem_wr) emem[m[R_MAR][7:0]] = m[R_WRB];
        @(posedge clk);
        #1;
        m = nm; mz = nz;
        @(negedge clk);
        idle();
    endtask

    // Read every register out on bus X without a clock edge.
    task automatic observe_all(string req);
        for (int i = 0; i < NREG; i++) begin
            idle();
            x_en = NREG'(1) << i;
            alu_fn = FN_PASSX;
            #0.2;
            chk(req, alu_out, m[i]);
        end
        idle();
        chk({req, " zero"}, {15'd0, zero}, {15'd0, mz});
    endtask

    task automatic load_reg(int idx, logic [15:0] v);
        tmem[m[R_MAR][7:0]] = v;
        emem[m[R_MAR][7:0]] = v;
        mem_rd = 1;
        step("R8 load");
        x_en = NREG'(1) << R_RDB; alu_fn = FN_PASSX; ld_en = NREG'(1) << idx;
        step("R3 load");
    endtask

    initial begin
        #(8 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        seed_dummy = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) begin
            tmem[i] = 16'(i * 16'h0101 + 16'h0F0F);
            emem[i] = tmem[i];
        end
        for (int i = 0; i < NREG; i++) m[i] = 16'd0;
        mz = 0;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1: reset state of every register and the flag.
        observe_all("R1 reset");

        // R2: empty bus reads zero.
        alu_fn = FN_PASSX; #0.2;
        chk("R2 empty X", alu_out, 16'd0);
        idle();

        load_reg(R_G0, 16'h1234);
        load_reg(R_G1, 16'hFFFF);

        // R2: Y bus carries its single source.
        y_en = NREG'(1) << R_G1; alu_fn = FN_PASSY; #0.2;
        chk("R2 Y bus", alu_out, 16'hFFFF);
        idle();

        // R4: every function code on fixed operands.
        for (int f = 0; f < 16; f++) begin
            x_en = NREG'(1) << R_G0; y_en = NREG'(1) << R_G1; alu_fn = 4'(f);
            step("R4 fn");
        end
        x_en = NREG'(1) << R_G0; y_en = NREG'(1) << R_G1; alu_fn = FN_ADD; #0.2;
        chk("R4 add wrap", alu_out, 16'h1233);
        alu_fn = FN_LTU; #0.2;
        chk("R4 ltu", alu_out, 16'h0001);
        alu_fn = FN_ASR; x_en = NREG'(1) << R_G1; #0.2;
        chk("R4 asr", alu_out, 16'hFFFF);
        idle();

        // R5: zero result sets flag; non-update cycle keeps it.
        load_reg(R_G0, 16'h0001);
        x_en = NREG'(1) << R_G0; y_en = NREG'(1) << R_G1; alu_fn = FN_ADD;
        flag_upd = 1; ld_en = NREG'(1) << R_W0;
        step("R5 set");
        chk("R5 flag set", {15'd0, zero}, 16'd1);
        x_en = NREG'(1) << R_G1; alu_fn = FN_PASSX;
        step("R5 hold");
        chk("R5 flag held", {15'd0, zero}, 16'd1);

        // R6: conditional PC load, flag set then clear.
        x_en = NREG'(1) << R_G1; alu_fn = FN_PASSX; ld_en = NREG'(1) << R_PC; pc_if_zero = 1;
        step("R6 taken");
        x_en = NREG'(1) << R_G1; alu_fn = FN_PASSX; flag_upd = 1;
        step("R5 clear");
        chk("R5 flag clear", {15'd0, zero}, 16'd0);
        x_en = NREG'(1) << R_G0; alu_fn = FN_PASSX; ld_en = NREG'(1) << R_PC; pc_if_zero = 1;
        step("R6 blocked");
        x_en = NREG'(1) << R_PC; alu_fn = FN_PASSX; #0.2;
        chk("R6 pc held", alu_out, 16'hFFFF);
        idle();

        // R7: stack pointer corners.
        load_reg(R_SP, 16'h0000);
        sp_dec = 1; step("R7 dec");
        x_en = NREG'(1) << R_SP; alu_fn = FN_PASSX; #0.2;
        chk("R7 underflow", alu_out, 16'hFFFF);
        idle();
        sp_inc = 1; sp_dec = 1; step("R7 both");
        sp_inc = 1; step("R7 inc");
        x_en = NREG'(1) << R_SP; alu_fn = FN_PASSX; #0.2;
        chk("R7 overflow", alu_out, 16'h0000);
        idle();
        x_en = NREG'(1) << R_G0; alu_fn = FN_PASSX; ld_en = NREG'(1) << R_SP; sp_inc = 1;
        step("R7 load wins");
        x_en = NREG'(1) << R_SP; alu_fn = FN_PASSX; #0.2;
        chk("R7 load wins", alu_out, 16'h0001);
        idle();

        // R8: write to memory, then read back with RDB load also requested.
        load_reg(R_MAR, 16'h0042);
        load_reg(R_WRB, 16'hBEEF);
        chk("R8 addr", mem_addr, 16'h0042);
        chk("R8 wdata", mem_wdata, 16'hBEEF);
        mem_wr = 1; #0.2;
        chk("R8 we strobe", {15'd0, mem_we}, 16'd1);
        step("R8 write");
        chk("R8 mem", tmem[8'h42], 16'hBEEF);
        mem_rd = 1; x_en = NREG'(1) << R_G0; alu_fn = FN_PASSX; ld_en = NREG'(1) << R_RDB;
        step("R8 read priority");
        x_en = NREG'(1) << R_RDB; alu_fn = FN_PASSX; #0.2;
        chk("R8 rdb", alu_out, 16'hBEEF);
        idle();

        // R3: one result captured into two destinations.
        x_en = NREG'(1) << R_G0; alu_fn = FN_NOTX;
        ld_en = (NREG'(1) << R_G1) | (NREG'(1) << R_RA);
        step("R3 multi");
        observe_all("R3 multi");

        // Random micro-operations against the model.
        for (int n = 0; n < 600; n++) begin
            if (($urandom % 8) != 0) x_en = NREG'(1) << ($urandom % NREG);
            if (($urandom % 8) != 0) y_en = NREG'(1) << ($urandom % NREG);
            ld_en      = NREG'($urandom & $urandom);
            alu_fn     = 4'($urandom);
            flag_upd   = 1'($urandom);
            pc_if_zero = 1'($urandom);
            sp_inc     = 1'($urandom);
            sp_dec     = 1'($urandom);
            mem_rd     = (($urandom % 4) == 0);
            mem_wr     = (($urandom % 4) == 0);
            step("R3/R4/R7 random");
            if ((n % 16) == 15) observe_all("R3 random state");
        end
        observe_all("R3 final");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule